// File: doc/BRIEF.md
# Hot-plug slot command completion tracker

This block holds the slot control register and the command-completed status flag of a downstream port that supports hot-plug. Software writes the control register through a configuration write strobe. The block decides whether that write is a hot-plug command. If it is, the block forwards the six control-field bits to a slot-management agent over a valid/ready handshake. Once the agent accepts them, the block raises the command-completed flag.

Two modes are supported, chosen by a static input. In conformant mode every write to the control register is a command. In legacy mode a write is a command only when it changes the indicator, power or interlock fields. A write that only changes other bits, such as notification enables, updates the register but never completes. A port strapped as not hot-plug capable never issues commands. If writes arrive while a delivery is still outstanding, one pending entry holds the latest one.

Top module: `slot_cmd_tracker`

## Requirements
- R1: After reset, `ctl_rdata` is 0, `sts_rdata` is 0 and `cmd_valid` is 0.
- R2: Every `ctl_wr` stores all 16 bits of `ctl_wdata`, visible on `ctl_rdata` in the next cycle, whatever the mode, the capability or the delivery state.
- R3: With `hp_capable`=1 and `legacy_mode`=0, every control write issues a command, even one that rewrites the same value. `cmd_valid` is 1 in the cycle after the write, and `cmd_data` equals `ctl_wdata[11:6]`. The order is {interlock bit 11, power controller bit 10, power indicator bits 9:8, attention indicator bits 7:6}.
- R4: With `legacy_mode`=1, a write issues a command only if `ctl_wdata[11:6]` differs from the stored bits 11:6.
- R5: In legacy mode, a write that changes only bits outside 11:6 updates the register but leaves `cmd_valid` at 0 and the completed flag at 0.
- R6: With `hp_capable`=0, no write issues a command in either mode.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` stays 1 and `cmd_data` is unchanged.
- R8: A clock edge with `cmd_valid` and `cmd_ready` both 1 sets the completed flag, which reads as `sts_rdata[4]`. The flag is visible from the following cycle.
- R9: A status write with `sts_wdata[4]`=1 clears the flag. A status write with bit 4 at 0 leaves it unchanged.
- R10: When a handshake and a clearing status write fall on the same edge, the flag ends set.
- R11: A command issued while another is outstanding goes into a single pending entry, and a later one overwrites it. After the outstanding command is accepted, `cmd_valid` stays 1 and `cmd_data` carries the latest pending fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_capable | input | 1 | Port strap: 1 when the slot supports hot-plug |
| legacy_mode | input | 1 | 1 selects change-only command detection |
| ctl_wr | input | 1 | Write strobe for the slot control register |
| ctl_wdata | input | 16 | Write data for the slot control register |
| sts_wr | input | 1 | Write strobe for the slot status register |
| sts_wdata | input | 16 | Status write data; bit 4 set clears the completed flag |
| ctl_rdata | output | 16 | Current slot control value |
| sts_rdata | output | 16 | Slot status; bit 4 is the completed flag, other bits 0 |
| cmd_valid | output | 1 | A command is offered to the slot agent |
| cmd_data | output | 6 | Control fields of the offered command |
| cmd_ready | input | 1 | Slot agent accepts the offered command |

## Verification
The hardest state to reach is a full pending entry behind an unaccepted command that is then overwritten. It matters because acceptance must hand over the latest fields and not the first ones queued. The bench holds `cmd_ready` low and issues three conformant writes back to back. It then releases `cmd_ready` for single cycles and checks which fields follow and when the valid drops. A second hard case is a handshake that lands on the same edge as a clearing status write. The bench reaches it by lining up `cmd_ready` and `sts_wr` in one cycle.

// File: rtl/slot_cmd_tracker.sv
module slot_cmd_tracker #(
  parameter int W      = 16,
  parameter int CC_BIT = 4,
  parameter int FLD_LO = 6,
  parameter int FLD_HI = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hp_capable,
  input  logic                     legacy_mode,
  input  logic                     ctl_wr,
  input  logic [W-1:0]             ctl_wdata,
  input  logic                     sts_wr,
  input  logic [W-1:0]             sts_wdata,
  output logic [W-1:0]             ctl_rdata,
  output logic [W-1:0]             sts_rdata,
  output logic                     cmd_valid,
  output logic [FLD_HI-FLD_LO:0]   cmd_data,
  input  logic                     cmd_ready
);
  localparam int FW = FLD_HI - FLD_LO + 1;

  logic [W-1:0]  ctl_q;
  logic          cc_q;
  logic          pend_q;
  logic [FW-1:0] pend_data_q;

  logic [FW-1:0] new_fld;
  logic          changed, issue, done, clr;

  assign new_fld = ctl_wdata[FLD_HI:FLD_LO];
  assign changed = new_fld != ctl_q[FLD_HI:FLD_LO];
  assign issue   = ctl_wr && hp_capable && (!legacy_mode || changed);
  assign done    = cmd_valid && cmd_ready;
  assign clr     = sts_wr && sts_wdata[CC_BIT];

  assign ctl_rdata = ctl_q;
  always_comb begin
    sts_rdata         = '0;
    sts_rdata[CC_BIT] = cc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= ctl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_data    <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else begin
      if (done) begin
        cmd_valid <= pend_q;
        cmd_data  <= pend_data_q;
        pend_q    <= 1'b0;
      end
      if (issue) begin
        if (!cmd_valid || (done && !pend_q)) begin
          cmd_valid <= 1'b1;
          cmd_data  <= new_fld;
        end else begin
          pend_q      <= 1'b1;
          pend_data_q <= new_fld;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cc_q <= 1'b0;
    else if (done) cc_q <= 1'b1;
    else if (clr)  cc_q <= 1'b0;
  end

  // R7
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  // R8
  set_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> sts_rdata[CC_BIT]);

  // R8
  rise_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rdata[CC_BIT]) |-> $past(cmd_valid && cmd_ready));

  // R6
  no_cmd_uncapable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !hp_capable && !cmd_valid && !pend_q |=> !cmd_valid);

  // R5
  legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && legacy_mode && (ctl_wdata[FLD_HI:FLD_LO] == ctl_rdata[FLD_HI:FLD_LO])
      && !cmd_valid && !pend_q |=> !cmd_valid);

  // R2
  ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata == $past(ctl_wdata));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && sts_wdata[CC_BIT] && !(cmd_valid && cmd_ready) |=> !sts_rdata[CC_BIT]);
endmodule

// File: tb/slot_cmd_tracker_tb.sv
module slot_cmd_tracker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        hp_capable = 1;
  logic        legacy_mode = 0;
  logic        ctl_wr = 0;
  logic [15:0] ctl_wdata = 0;
  logic        sts_wr = 0;
  logic [15:0] sts_wdata = 0;
  logic [15:0] ctl_rdata, sts_rdata;
  logic        cmd_valid;
  logic [5:0]  cmd_data;
  logic        cmd_ready = 0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  slot_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .hp_capable(hp_capable), .legacy_mode(legacy_mode),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [15:0] d);
    ctl_wr = 1; ctl_wdata = d;
    cyc();
    ctl_wr = 0;
  endtask

  task automatic clear_cc();
    sts_wr = 1; sts_wdata = 16'h0010;
    cyc();
    sts_wr = 0; sts_wdata = 0;
  endtask

  // {legacy, capable, write data, command expected}
  typedef struct packed { logic leg; logic cap; logic [15:0] d; logic cmd; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 16'h0000, 1'b1},
    '{1'b0, 1'b1, 16'h0FC0, 1'b1},
    '{1'b1, 1'b1, 16'h0FC0, 1'b0},
    '{1'b1, 1'b1, 16'h0FDF, 1'b0},
    '{1'b1, 1'b1, 16'h0F5F, 1'b1},
    '{1'b1, 1'b0, 16'h001F, 1'b0},
    '{1'b0, 1'b0, 16'h001F, 1'b0},
    '{1'b0, 1'b1, 16'h0A40, 1'b1}
  };

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    // R1
    chk(ctl_rdata == 0, "R1 ctl", ctl_rdata, 0);
    chk(sts_rdata == 0, "R1 sts", sts_rdata, 0);
    chk(cmd_valid == 0, "R1 valid", cmd_valid, 0);

    for (int i = 0; i < 8; i++) begin
      legacy_mode = VECS[i].leg;
      hp_capable  = VECS[i].cap;
      wr_ctl(VECS[i].d);
      chk(ctl_rdata == VECS[i].d, "R2 store", ctl_rdata, VECS[i].d);
      chk(cmd_valid == VECS[i].cmd, "R3/R4/R5/R6 issue", cmd_valid, VECS[i].cmd);
      if (VECS[i].cmd) begin
        chk(cmd_data == VECS[i].d[11:6], "R3 fields", cmd_data, VECS[i].d[11:6]);
        cmd_ready = 1;
        cyc();
        cmd_ready = 0;
        chk(sts_rdata[4] == 1, "R8 set", sts_rdata[4], 1);
        chk(cmd_valid == 0, "R8 drop", cmd_valid, 0);
        clear_cc();
        chk(sts_rdata[4] == 0, "R9 clear", sts_rdata[4], 0);
      end else begin
        cyc(2);
        chk(cmd_valid == 0 && sts_rdata[4] == 0, "R5/R6 quiet",
            {cmd_valid, sts_rdata[4]}, 0);
      end
    end

    // R7: offer held while not ready
    legacy_mode = 0; hp_capable = 1;
    wr_ctl(16'h0540);
    cyc(3);
    chk(cmd_valid == 1 && cmd_data == 6'h15, "R7 hold", {cmd_valid, cmd_data}, {1'b1, 6'h15});

    // R10: accept and clear on same edge -> set
    cmd_ready = 1; sts_wr = 1; sts_wdata = 16'h0010;
    cyc();
    cmd_ready = 0; sts_wr = 0; sts_wdata = 0;
    chk(sts_rdata[4] == 1, "R10 set wins", sts_rdata[4], 1);

    // R9: bit 4 clear has no effect
    sts_wr = 1; sts_wdata = 16'hFFEF;
    cyc();
    sts_wr = 0; sts_wdata = 0;
    chk(sts_rdata[4] == 1, "R9 no clear", sts_rdata[4], 1);
    clear_cc();
    chk(sts_rdata[4] == 0, "R9 clear", sts_rdata[4], 0);

    // R11: queue with overwrite
    wr_ctl(16'h0040);
    wr_ctl(16'h0080);
    wr_ctl(16'h0C00);
    chk(ctl_rdata == 16'h0C00, "R2 busy store", ctl_rdata, 16'h0C00);
    chk(cmd_data == 6'h01, "R11 first", cmd_data, 6'h01);
    cmd_ready = 1;
    cyc();
    cmd_ready = 0;
    chk(cmd_valid == 1 && cmd_data == 6'h30, "R11 latest", {cmd_valid, cmd_data}, {1'b1, 6'h30});
    chk(sts_rdata[4] == 1, "R8 queued set", sts_rdata[4], 1);
    cmd_ready = 1;
    cyc();
    cmd_ready = 0;
    chk(cmd_valid == 0, "R11 drained", cmd_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule